// File: doc/BRIEF.md
# Video Input Active-Window Qualifier

This block sits at the input of a digital video encoder. On every rising edge of the double-rate sample clock it captures a luma byte, a chroma byte, a low-active horizontal sync and a low-active blank flag. It then decides which of those samples are real picture samples. A counter starts on the falling edge of the sync and measures how many sample clocks have elapsed since then. Once a start offset has passed, an active window opens for a fixed number of clocks. Inside that window a sample is valid while the blank flag is high, unless a line-level blanking input holds the whole line blank.

The start offset depends on the video standard (525-line or 625-line) and on whether the encoder generates the timing (master) or follows it (slave). The offset is the same for separate luma and chroma buses and for one multiplexed 8-bit bus. The block tags every valid chroma sample as Cb or Cr. The first valid sample of a line is always Cb.

The outputs are the captured samples, a valid strobe and the chroma tag. All of them are registered one clock after the input edge.

Top module: `vid_win_qual`

## Requirements
- R1: `y_out` and `c_out` equal the `y_in` and `c_in` values captured at the previous rising clock edge.
- R2: The sample captured on the edge where `hsync_n` is first seen low after being high has offset 0. Each later sample adds 1. A sample is inside the window when START <= offset < START + ACT_LEN. No sample is valid before the first sync falling edge after reset.
- R3: START is 250 in master 525-line mode, 280 in master 625-line mode, 260 in slave 525-line mode and 290 in slave 625-line mode. `std_625` = 1 selects 625-line and `slave_mode` = 1 selects slave.
- R4: A sample inside the window is valid only while `blank_n` is high.
- R5: While `line_blank` is high, no sample is valid, even when `blank_n` is high inside the window.
- R6: `cr_tag` is 0 (Cb) on the first valid sample of a line and alternates on each later valid sample of that line. The alternation restarts at Cb after every sync falling edge. `cr_tag` is 0 whenever `pix_valid` is 0.
- R7: A new sync falling edge closes an open window at once, even when fewer than ACT_LEN samples have been in it.
- R8: The window closes after ACT_LEN samples, so no line yields more than ACT_LEN valid samples.
- R9: During and right after reset, `y_out`, `c_out`, `pix_valid` and `cr_tag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate sample clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| std_625 | input | 1 | 1 = 625-line standard, 0 = 525-line standard |
| slave_mode | input | 1 | 1 = slave timing, 0 = master timing |
| y_in | input | DW | Luma sample |
| c_in | input | DW | Chroma sample (Cb/Cr interleaved) |
| hsync_n | input | 1 | Horizontal sync, active low |
| blank_n | input | 1 | Blank flag, active low (high = picture) |
| line_blank | input | 1 | Whole-line blanking from the line counter |
| y_out | output | DW | Registered luma |
| c_out | output | DW | Registered chroma |
| pix_valid | output | 1 | Registered valid strobe |
| cr_tag | output | 1 | 1 = Cr, 0 = Cb, for the valid chroma sample |

## Verification
The hardest case to reach is a window cut short by the next sync edge. That needs a line shorter than START + ACT_LEN, followed straight away by another falling edge. The window must also stay exactly aligned to the right mode-dependent offset. The bench makes ACT_LEN small and drives whole lines of exact lengths. One line is deliberately too short, so its window is cut after only part of its samples. Blank gaps at odd positions then show that the Cb/Cr alternation restarts after that truncated line.

// File: rtl/vid_win_qual.sv
module vid_win_qual #(
  parameter int DW         = 8,
  parameter int ACT_LEN    = 1440,
  parameter int START_M525 = 250,
  parameter int START_M625 = 280,
  parameter int START_S525 = 260,
  parameter int START_S625 = 290
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          std_625,
  input  logic          slave_mode,
  input  logic [DW-1:0] y_in,
  input  logic [DW-1:0] c_in,
  input  logic          hsync_n,
  input  logic          blank_n,
  input  logic          line_blank,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] c_out,
  output logic          pix_valid,
  output logic          cr_tag
);

  localparam int MAXSTART = (START_S625 > START_M625) ? START_S625 : START_M625;
  localparam int CW = $clog2(MAXSTART + ACT_LEN + 2) + 1;
  localparam logic [CW-1:0] CMAX = '1;

  logic          hs_q, armed_q, phase_q;
  logic [CW-1:0] off_q, off_d, start;
  logic          fall, in_win, take;

  assign fall = hs_q & ~hsync_n;

  always_comb begin
    case ({slave_mode, std_625})
      2'b00:   start = CW'(START_M525);
      2'b01:   start = CW'(START_M625);
      2'b10:   start = CW'(START_S525);
      default: start = CW'(START_S625);
    endcase
  end

  assign off_d  = fall ? '0 : ((off_q == CMAX) ? off_q : off_q + 1'b1);
  assign in_win = (armed_q | fall) && (off_d >= start) && (off_d < start + CW'(ACT_LEN));
  assign take   = in_win & blank_n & ~line_blank;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q      <= 1'b1;
      armed_q   <= 1'b0;
      off_q     <= CMAX;
      phase_q   <= 1'b0;
      y_out     <= '0;
      c_out     <= '0;
      pix_valid <= 1'b0;
      cr_tag    <= 1'b0;
    end else begin
      hs_q      <= hsync_n;
      armed_q   <= armed_q | fall;
      off_q     <= off_d;
      y_out     <= y_in;
      c_out     <= c_in;
      pix_valid <= take;
      cr_tag    <= take & (fall ? 1'b0 : phase_q);
      if (fall)      phase_q <= take;
      else if (take) phase_q <= ~phase_q;
    end
  end

  // checker state
  logic [CW-1:0] vcnt_q;
  logic          first_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt_q  <= '0;
      first_q <= 1'b0;
    end else begin
      if (fall)           vcnt_q <= '0;
      else if (pix_valid) vcnt_q <= vcnt_q + 1'b1;
      if (fall)           first_q <= 1'b1;
      else if (pix_valid) first_q <= 1'b0;
    end
  end

  assert_blank_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> $past(blank_n));
  assert_line_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !$past(line_blank));
  assert_sync_closes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync_n) |=> !pix_valid);
  assert_first_is_cb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && first_q) |-> !cr_tag);
  assert_tag_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> !cr_tag);
  assert_win_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt_q <= CW'(ACT_LEN));

endmodule

// File: tb/vid_win_qual_tb_top.sv
module vid_win_qual_tb_top;
  localparam int DW  = 8;
  localparam int ACT = 40;

  logic clk = 0, rst_n = 0;
  logic std_625 = 0, slave_mode = 0;
  logic [DW-1:0] y_in = 0, c_in = 0;
  logic hsync_n = 1, blank_n = 0, line_blank = 0;
  logic [DW-1:0] y_out, c_out;
  logic pix_valid, cr_tag;

  always #4 clk = ~clk;

  vid_win_qual #(.DW(DW), .ACT_LEN(ACT)) dut_i (
    .clk(clk), .rst_n(rst_n), .std_625(std_625), .slave_mode(slave_mode),
    .y_in(y_in), .c_in(c_in), .hsync_n(hsync_n), .blank_n(blank_n),
    .line_blank(line_blank), .y_out(y_out), .c_out(c_out),
    .pix_valid(pix_valid), .cr_tag(cr_tag));

  typedef struct {
    logic [DW-1:0] y, c;
    logic v, t;
    string req;
  } exp_t;

  exp_t q[$];
  int vectors = 0, errors = 0;
  bit done = 0;

  task automatic push(input logic [DW-1:0] y, input logic [DW-1:0] c,
                      input logic v, input logic t, input string req);
    exp_t e;
    e.y = y; e.c = c; e.v = v; e.t = t; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hsync_n = 1; blank_n = 1; line_blank = 0;
      y_in = 8'(i + 7); c_in = 8'(i * 3);
      push(y_in, c_in, 0, 0, "R2");
    end
  endtask

  // len: clocks in line; gap: blank_n low where k%gap==1 (0 = none)
  task automatic line(input bit pal, input bit slv, input int len,
                      input int gap, input bit lb, input string req);
    int st;
    bit ph;
    bit v;
    st = slv ? (pal ? 290 : 260) : (pal ? 280 : 250);
    ph = 0;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      std_625 = pal; slave_mode = slv;
      hsync_n = (k >= 64);
      blank_n = (gap == 0) ? 1'b1 : ((k % gap) != 1);
      line_blank = lb;
      y_in = 8'(k); c_in = ~8'(k);
      v = (k >= st) && (k < st + ACT) && blank_n && !lb;
      push(y_in, c_in, v, v ? ph : 1'b0, req);
      if (v) ph = ~ph;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (rst_n && q.size() > 0) begin
        e = q.pop_front();
        vectors++;
        if (y_out !== e.y || c_out !== e.c) begin
          errors++;
          $display("FAIL R1 y/c got %h/%h exp %h/%h", y_out, c_out, e.y, e.c);
        end
        if (pix_valid !== e.v || cr_tag !== e.t) begin
          errors++;
          $display("FAIL %s valid/tag got %b/%b exp %b/%b", e.req, pix_valid, cr_tag, e.v, e.t);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    vectors++;
    if (y_out !== 0 || c_out !== 0 || pix_valid !== 0 || cr_tag !== 0) begin
      errors++;
      $display("FAIL R9 reset outputs got %h %h %b %b exp 0", y_out, c_out, pix_valid, cr_tag);
    end
    rst_n = 1;
    idle(20);                       // R2: nothing valid before first sync
    line(0, 0, 400, 0, 0, "R3");    // master 525
    line(1, 0, 400, 0, 0, "R3");    // master 625
    line(0, 1, 400, 0, 0, "R3");    // slave 525
    line(1, 1, 400, 0, 0, "R8");    // slave 625, full window closes at ACT
    line(0, 0, 400, 7, 0, "R4");    // blank gaps
    line(1, 1, 400, 0, 1, "R5");    // whole line blanked
    line(0, 0, 270, 0, 0, "R7");    // cut short by next sync
    line(0, 0, 400, 5, 0, "R6");    // tag restarts at Cb
    line(1, 0, 400, 3, 0, "R6");
    idle(4);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule